// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character from a host into an asynchronous serial frame. The host writes a character of up to eight bits into a holding register with a load strobe. As soon as the shifter is idle the character moves into it, and the holding register is free for the next one. The frame is a low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits. The line rests high between frames.

The frame format comes from a control word that the host latches with a separate strobe. A two-bit length code selects five to eight data bits. Parity can be inhibited, or it can be even or odd. A stop select gives one stop bit, or a longer stop period: two bits for six to eight bit characters, and one and a half bits for five-bit characters. Timing is driven by a one-cycle tick at sixteen times the bit rate. The host sees two flags. One says the holding register is free. The other says the whole transmitter has gone quiet.

Top module: `sertx_top`

## Requirements
- R1: While reset is high and on the first clock after it falls, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1. The control word resets to eight data bits, parity inhibited, one stop bit.
- R2: A high `ld` at a clock edge writes `din` and drives `hold_empty` to 0 after that edge. If the shifter is idle, the word moves into it on the next edge. `hold_empty` returns to 1 at that same edge, and `txd` goes to 0.
- R3: Every frame starts with one low start bit. Every bit, start bit included, lasts exactly 16 `tick` pulses. Data bits go out least significant bit first. `txd` changes only at the edge where the word moves into the shifter or at a `tick` edge.
- R4: The latched length code gives the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `din` above the selected length are never sent.
- R5: With the latched parity-inhibit bit at 1, no parity bit is sent, and the stop period follows the last data bit directly.
- R6: With parity enabled, a parity bit follows the data bits. Even-select 1 makes the count of ones over the selected data bits plus parity even. Even-select 0 makes that count odd.
- R7: With the stop select at 0, the line stays high for 16 ticks after the last data or parity bit. With the stop select at 1 and a length of 6 to 8 bits, it stays high for 32 ticks.
- R8: With the stop select at 1 and a length of 5 bits, the line stays high for 24 ticks after the last data or parity bit.
- R9: `tx_empty` is 1 only when the holding register is empty and no frame is in progress, including its stop period. It rises at the tick edge that ends the last stop tick.
- R10: Reset in the middle of a frame abandons the frame and the held word. After reset `txd` is 1 and both flags are 1.
- R11: A word loaded while a frame is in progress waits in the holding register. It moves into the shifter on the first clock after the stop period ends, and `hold_empty` rises at that edge.
- R12: The control word is taken from the `cfg_*` pins only on a clock edge with `cfg_we` high. The format of a frame is fixed when its word moves into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| cfg_we | input | 1 | Latch strobe for the control word |
| cfg_len | input | 2 | Length code, 00 to 11 for 5 to 8 data bits |
| cfg_stop_sel | input | 1 | Stop select: 0 for one stop bit, 1 for the longer stop period |
| cfg_par_off | input | 1 | 1 inhibits the parity bit |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd parity |
| ld | input | 1 | Load strobe for the holding register |
| din | input | DATA_W | Character from the host |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
A load strobe shows on `hold_empty` after one edge. When the shifter is idle, the transfer follows one edge later, and `txd` falls and `hold_empty` rises at that edge. After that, every line change waits for a tick edge: 16 ticks per bit, then 16, 24 or 32 ticks of stop. `tx_empty` rises at the edge of the last stop tick. The bench keeps a tick-level model that builds each frame as a queue of line values, one per tick, in the same edge where the design takes the word. It compares the three outputs at every falling clock edge, so each result is checked in the cycle it is due. A few directed checks also sample the flags one and two edges after a load.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Latched frame-format control word
  typedef struct packed {
    logic [1:0] len;       // data length code, length = minimum + code
    logic       stop_sel;  // 0: one stop bit, 1: longer stop period
    logic       par_off;   // 1: no parity bit
    logic       par_even;  // 1: even parity, 0: odd parity
  } sertx_cfg_t;

  localparam sertx_cfg_t CFG_RESET = '{len: 2'b11, stop_sel: 1'b0,
                                       par_off: 1'b1, par_even: 1'b0};

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_BITS = 2'd1,
    SH_STOP = 2'd2
  } sertx_state_t;

endpackage

// File: rtl/sertx_cfg.sv
module sertx_cfg
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  sertx_cfg_t cfg_in,
  output sertx_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= CFG_RESET;
    else if (we) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic              empty,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      data  <= '0;
    end else begin
      if (ld) begin
        data  <= din;
        empty <= 1'b0;
      end else if (take) begin
        empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_fmt.sv
module sertx_fmt
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int FW    = DATA_W + 2,
  localparam int CNTW  = $clog2(DATA_W + 3),
  localparam int STW   = $clog2(2 * OVS + 1),
  localparam int MIN_W = DATA_W - 3
) (
  input  sertx_cfg_t        cfg,
  input  logic [DATA_W-1:0] data,
  output logic [FW-1:0]     frame,
  output logic [CNTW-1:0]   nbits,
  output logic [STW-1:0]    stop_ticks
);
  int   n;
  logic ones;
  logic par;

  always_comb begin
    n    = MIN_W + int'(cfg.len);
    ones = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) ones = ones ^ data[i];
    end
    par = cfg.par_even ? ones : ~ones;

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n)                       frame[i+1] = data[i];
      else if (i == n && !cfg.par_off) frame[i+1] = par;
    end
    if (n == DATA_W && !cfg.par_off) frame[FW-1] = par;

    nbits = CNTW'(1 + n + (cfg.par_off ? 0 : 1));

    if (!cfg.stop_sel)       stop_ticks = STW'(OVS);
    else if (cfg.len == '0)  stop_ticks = STW'(OVS + OVS / 2);
    else                     stop_ticks = STW'(2 * OVS);
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int FW    = DATA_W + 2,
  localparam int CNTW  = $clog2(DATA_W + 3),
  localparam int STW   = $clog2(2 * OVS + 1),
  localparam int SUBW  = $clog2(OVS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  logic [FW-1:0]   frame,
  input  logic [CNTW-1:0] nbits,
  input  logic [STW-1:0]  stop_ticks,
  output logic            busy,
  output logic            txd
);
  sertx_state_t    st;
  logic [FW-1:0]   sh;
  logic [SUBW-1:0] sub;
  logic [CNTW-1:0] left;
  logic [STW-1:0]  stc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SH_IDLE;
      txd  <= 1'b1;
      sh   <= '1;
      sub  <= '0;
      left <= '0;
      stc  <= '0;
    end else begin
      case (st)
        SH_IDLE: begin
          if (start) begin
            st   <= SH_BITS;
            txd  <= frame[0];
            sh   <= {1'b1, frame[FW-1:1]};
            left <= nbits - CNTW'(1);
            sub  <= '0;
            stc  <= stop_ticks - STW'(1);
          end
        end
        SH_BITS: begin
          if (tick) begin
            if (sub == SUBW'(OVS - 1)) begin
              sub <= '0;
              if (left == '0) begin
                st  <= SH_STOP;
                txd <= 1'b1;
              end else begin
                left <= left - CNTW'(1);
                txd  <= sh[0];
                sh   <= {1'b1, sh[FW-1:1]};
              end
            end else begin
              sub <= sub + SUBW'(1);
            end
          end
        end
        SH_STOP: begin
          if (tick) begin
            if (stc == '0) st <= SH_IDLE;
            else           stc <= stc - STW'(1);
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign busy = (st != SH_IDLE);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop_sel,
  input  logic              cfg_par_off,
  input  logic              cfg_par_even,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  localparam int FW   = DATA_W + 2;
  localparam int CNTW = $clog2(DATA_W + 3);
  localparam int STW  = $clog2(2 * OVS + 1);

  sertx_cfg_t        cfg_in, cfg_q;
  logic [DATA_W-1:0] hold_data;
  logic [FW-1:0]     frame;
  logic [CNTW-1:0]   nbits;
  logic [STW-1:0]    stop_ticks;
  logic              busy;
  logic              take;

  assign cfg_in = '{len: cfg_len, stop_sel: cfg_stop_sel,
                    par_off: cfg_par_off, par_even: cfg_par_even};

  sertx_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  assign take = ~busy & ~hold_empty;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .ld    (ld),
    .din   (din),
    .take  (take),
    .empty (hold_empty),
    .data  (hold_data)
  );

  sertx_fmt #(.DATA_W(DATA_W), .OVS(OVS)) u_fmt (
    .cfg        (cfg_q),
    .data       (hold_data),
    .frame      (frame),
    .nbits      (nbits),
    .stop_ticks (stop_ticks)
  );

  sertx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .start      (take),
    .frame      (frame),
    .nbits      (nbits),
    .stop_ticks (stop_ticks),
    .busy       (busy),
    .txd        (txd)
  );

  assign tx_empty = hold_empty & ~busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic ld,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txd && hold_empty && tx_empty)); // R1

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ld |=> !hold_empty); // R2

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ($rose(txd) && !$past(rst)) |-> $past(tick)); // R3

  AST_FALL_ON_TICK_OR_TAKE: assert property (@(posedge clk) disable iff (rst)
    ($fell(txd) && !$past(rst)) |-> ($past(tick) || !$past(hold_empty))); // R3

  AST_EMPTY_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> (txd && hold_empty)); // R9
endmodule

bind sertx_top sertx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .ld         (ld),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_stop_sel = 1'b0;
  logic       cfg_par_off = 1'b1;
  logic       cfg_par_even = 1'b0;
  logic       ld = 1'b0;
  logic [7:0] din = '0;
  logic       txd, hold_empty, tx_empty;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;
  bit    started = 1'b0;

  always #2 clk = ~clk;

  sertx_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_stop_sel(cfg_stop_sel), .cfg_par_off(cfg_par_off),
    .cfg_par_even(cfg_par_even), .ld(ld), .din(din), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  // tick every third clock
  initial begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tc++;
      tick = (tc % 3 == 0);
    end
  end

  // ---------------- reference model: one line value per tick ----------------
  bit       mq[$];
  bit       m_busy = 0, m_full = 0, m_tx = 1;
  bit [7:0] m_hold = 0;
  int       m_len = 3;
  bit       m_stop2 = 0, m_poff = 1, m_peven = 0;

  task automatic build_frame(input bit [7:0] d);
    int n = 5 + m_len;
    int ones = 0;
    int stop_len;
    mq.delete();
    repeat (16) mq.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      repeat (16) mq.push_back(d[i]);
      ones += d[i];
    end
    if (!m_poff) begin
      bit p = m_peven ? bit'(ones % 2) : bit'(1 - ones % 2);
      repeat (16) mq.push_back(p);
    end
    stop_len = !m_stop2 ? 16 : (n == 5 ? 24 : 32);
    repeat (stop_len) mq.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    bit take;
    started = 1'b1;
    if (rst) begin
      mq.delete();
      m_busy = 0; m_full = 0; m_tx = 1;
      m_len = 3; m_stop2 = 0; m_poff = 1; m_peven = 0;
    end else begin
      take = !m_busy && m_full;
      if (m_busy && tick) begin
        void'(mq.pop_front());
        if (mq.size() == 0) begin m_busy = 0; m_tx = 1; end
        else m_tx = mq[0];
      end
      if (take) begin
        build_frame(m_hold);
        m_busy = 1;
        m_tx = mq[0];
      end
      if (ld) begin m_hold = din; m_full = 1; end
      else if (take) m_full = 0;
      if (cfg_we) begin
        m_len = int'(cfg_len); m_stop2 = cfg_stop_sel;
        m_poff = cfg_par_off; m_peven = cfg_par_even;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      check(cur_req, "txd", txd, m_tx);
      check(cur_req, "hold_empty", hold_empty, !m_full);
      check(cur_req, "tx_empty", tx_empty, !m_full && !m_busy);
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_cfg(input bit [1:0] len, input bit s2, input bit poff, input bit pev);
    @(posedge clk); #1;
    cfg_len = len; cfg_stop_sel = s2; cfg_par_off = poff; cfg_par_even = pev;
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic load(input bit [7:0] d);
    @(posedge clk); #1;
    din = d; ld = 1'b1;
    @(posedge clk); #1;
    ld = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (!tx_empty && guard < 5000) begin @(negedge clk); guard++; end
    check(cur_req, "frame finished", tx_empty, 1);
  endtask

  task automatic send(input bit [7:0] d);
    load(d);
    wait_idle();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "txd in reset", txd, 1);
    check("R1", "hold_empty in reset", hold_empty, 1);
    check("R1", "tx_empty in reset", tx_empty, 1);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "txd after reset", txd, 1);

    // R2: flag timing of a load into an idle transmitter
    cur_req = "R2";
    @(posedge clk); #1; din = 8'hA5; ld = 1'b1;
    @(posedge clk); #1; ld = 1'b0;
    @(negedge clk);
    check("R2", "hold_empty after load", hold_empty, 0);
    @(negedge clk);
    check("R2", "hold_empty after transfer", hold_empty, 1);
    check("R2", "start bit after transfer", txd, 0);
    check("R9", "tx_empty during frame", tx_empty, 0);
    cur_req = "R3";
    wait_idle();

    cur_req = "R4";
    set_cfg(2'b00, 0, 1, 0); send(8'hE5);
    set_cfg(2'b01, 0, 1, 0); send(8'hDA);
    set_cfg(2'b10, 0, 1, 0); send(8'h81);
    cur_req = "R5";
    set_cfg(2'b11, 0, 1, 1); send(8'h3C);

    cur_req = "R6";
    set_cfg(2'b11, 0, 0, 1); send(8'h07);
    set_cfg(2'b11, 0, 0, 0); send(8'h07);
    set_cfg(2'b01, 0, 0, 0); send(8'hC0);
    set_cfg(2'b10, 0, 0, 1); send(8'hFF);

    cur_req = "R7";
    set_cfg(2'b11, 1, 0, 1); send(8'h5A);
    set_cfg(2'b01, 1, 1, 0); send(8'h2B);

    cur_req = "R8";
    set_cfg(2'b00, 1, 1, 0); send(8'h15);
    set_cfg(2'b00, 1, 0, 0); send(8'h0A);

    cur_req = "R12";
    @(posedge clk); #1;
    cfg_len = 2'b00; cfg_par_off = 1'b0; cfg_stop_sel = 1'b0;
    send(8'hF0);

    cur_req = "R11";
    set_cfg(2'b11, 0, 0, 0);
    load(8'h11);
    repeat (5) @(posedge clk);
    load(8'h22);
    @(negedge clk);
    check("R11", "second word waits", hold_empty, 0);
    set_cfg(2'b00, 1, 1, 0);  // takes effect for the waiting word only at its transfer
    wait_idle();

    cur_req = "R10";
    load(8'h99);
    load(8'h66);
    repeat (40) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R10", "txd after mid-frame reset", txd, 1);
    check("R10", "hold_empty after mid-frame reset", hold_empty, 1);
    check("R10", "tx_empty after mid-frame reset", tx_empty, 1);
    cur_req = "R9";
    send(8'h42);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule